// File: doc/BRIEF.md
# External Bus Address Window Decoder

This block sits between an internal memory-mapped request port and an external bus controller. For each request it registers one of two active-low chip selects, the local offset inside the selected window, or a bus-fault indication. The result is returned one cycle after the request, together with a done pulse, so a requester is never left waiting.

Two windows are available: a peripheral window and a memory window. Each window has a 2-bit base selector and a 2-bit size code, held in one software-writable 32-bit configuration register. A base selector of zero turns its window off. Values one to three select one of three fixed, aligned 256 MB system regions, which are set by parameters. In dual-select mode, the base selectors that are non-zero decide the steering. Either one window is shared between both selects, split by the top bit of its range, or each select gets its own window. A half-word mode doubles the usable span and drives the offset on 2-byte boundaries.

Top module: `ebus_win_decode`

## Requirements
- R1: The configuration register resets to zero. A write stores data bits 7:0: memory base selector in 1:0, memory size in 3:2, peripheral base selector in 5:4 and peripheral size in 7:6. Read bits 31:8 always return zero.
- R2: A window hits only when its base selector is non-zero and address bits 31:28 equal the region picked by that selector (defaults: 1 → 0x6, 2 → 0x8, 3 → 0xA).
- R3: Size code 0/1/2/3 gives a span of 256 B / 64 KB / 16 MB / 256 MB. The offset driven out is the address minus the window base.
- R4: A request that hits no enabled window gives done=1, fault=0, both selects high and offset 0.
- R5: A hit whose offset is at or beyond the span gives fault=1, both selects high and offset 0.
- R6: In single mode (dual_mode=0), a hit asserts only cs0_n. The peripheral window wins when both windows match.
- R7: In dual mode with exactly one non-zero base selector, that window serves both selects. Offsets in the upper half of its span assert cs1_n, the rest assert cs0_n, and the top range bit is cleared from the driven offset.
- R8: In dual mode with both base selectors non-zero, a peripheral hit asserts cs0_n and a memory hit asserts cs1_n. The peripheral window wins on overlap.
- R9: With half_mode=1, the span doubles (capped at 256 MB) and the driven offset is shifted right by one.
- R10: Outputs are registered one cycle after req_valid. dec_done is high exactly in the cycle after a valid request, and both selects are high whenever dec_done is low.
- R11: cs0_n and cs1_n are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| dual_mode | input | 1 | 1 = two chip selects, 0 = cs0 only |
| half_mode | input | 1 | 1 = 16-bit bus without byte selects |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request system address |
| dec_done | output | 1 | Decode result valid |
| dec_fault | output | 1 | Bus fault for the request |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| dec_offset | output | 28 | Offset driven to the external bus |

## Verification
The bench sweeps all 256 register values under both select modes and both bus widths. For each setting it sends addresses in every fixed region and in one unmapped region. The offsets are placed at each span limit, one byte past it, and at each half-span point. The limit and past-limit offsets separate wrap from fault for each size code. The half-span offsets show where the shared-window split lies. Register settings in which only one selector is non-zero are compared with settings in which both are, which separates shared steering from split steering, including overlaps where both windows name the same region.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

    // Configuration field layout, most significant field first (bits 7:0).
    typedef struct packed {
        logic [1:0] per_size;
        logic [1:0] per_base;
        logic [1:0] mem_size;
        logic [1:0] mem_base;
    } ebw_cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CS0  = 2'd1,
        SEL_CS1  = 2'd2
    } ebw_sel_e;

    localparam int unsigned CFG_BITS = $bits(ebw_cfg_t);

    // Number of offset bits a window decodes, for a size code and bus width.
    function automatic int unsigned span_bits(input logic [1:0] code,
                                              input logic half,
                                              input int unsigned cap);
        int unsigned n;
        case (code)
            2'd0:    n = 8;
            2'd1:    n = 16;
            2'd2:    n = 24;
            default: n = 28;
        endcase
        if (half) n = n + 1;
        if (n > cap) n = cap;
        return n;
    endfunction

endpackage

// File: rtl/ebw_cfg_reg.sv
module ebw_cfg_reg
    import ebw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CFG_BITS-1:0] wdata,
    output ebw_cfg_t      cfg,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= ebw_cfg_t'(wdata);
    end

    assign rdata = {{(DW-CFG_BITS){1'b0}}, cfg};
endmodule

// File: rtl/ebw_window.sv
module ebw_window
    import ebw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int WOFS = 28,
    parameter logic [AW-WOFS-1:0] RGN1 = (AW-WOFS)'(6),
    parameter logic [AW-WOFS-1:0] RGN2 = (AW-WOFS)'(8),
    parameter logic [AW-WOFS-1:0] RGN3 = (AW-WOFS)'(10)
) (
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      base_sel,
    input  logic [1:0]      size_code,
    input  logic            half,
    output logic            hit,
    output logic            over,
    output logic [WOFS-1:0] top_bit,
    output logic [WOFS-1:0] ofs
);
    localparam int RB = AW - WOFS;

    logic [RB-1:0]   region;
    logic [WOFS:0]   one_sh;
    logic [WOFS-1:0] mask;
    logic [WOFS-1:0] raw;
    int unsigned     nbits;

    always_comb begin
        case (base_sel)
            2'd1:    region = RGN1;
            2'd2:    region = RGN2;
            default: region = RGN3;
        endcase
    end

    assign raw    = addr[WOFS-1:0];
    assign hit    = (base_sel != 2'd0) && (addr[AW-1:WOFS] == region);
    assign nbits  = span_bits(size_code, half, WOFS);
    assign one_sh = {{WOFS{1'b0}}, 1'b1} << nbits;
    assign mask   = one_sh[WOFS-1:0] - 1'b1;
    assign top_bit = one_sh[WOFS:1];
    assign over   = |(raw & ~mask);
    assign ofs    = raw & mask;
endmodule

// File: rtl/ebw_steer.sv
module ebw_steer
    import ebw_pkg::*;
#(
    parameter int WOFS = 28
) (
    input  logic            dual,
    input  logic            half,
    input  logic            per_en,
    input  logic            mem_en,
    input  logic            p_hit,
    input  logic            p_over,
    input  logic [WOFS-1:0] p_top,
    input  logic [WOFS-1:0] p_ofs,
    input  logic            m_hit,
    input  logic            m_over,
    input  logic [WOFS-1:0] m_top,
    input  logic [WOFS-1:0] m_ofs,
    output ebw_sel_e        sel,
    output logic            fault,
    output logic [WOFS-1:0] ofs_out
);
    logic            use_p, use_m, shared, hit, over;
    logic [WOFS-1:0] top, ofs;

    always_comb begin
        use_p  = 1'b0;
        use_m  = 1'b0;
        shared = 1'b0;
        if (!dual || (per_en && mem_en)) begin
            use_p = p_hit;
            use_m = !p_hit && m_hit;
        end else if (per_en) begin
            use_p  = p_hit;
            shared = 1'b1;
        end else if (mem_en) begin
            use_m  = m_hit;
            shared = 1'b1;
        end

        hit  = use_p || use_m;
        over = use_p ? p_over : m_over;
        top  = use_p ? p_top  : m_top;
        ofs  = use_p ? p_ofs  : m_ofs;

        sel     = SEL_NONE;
        fault   = 1'b0;
        ofs_out = '0;
        if (hit) begin
            if (over) begin
                fault = 1'b1;
            end else begin
                if (!dual)       sel = SEL_CS0;
                else if (shared) sel = (|(ofs & top)) ? SEL_CS1 : SEL_CS0;
                else             sel = use_p ? SEL_CS0 : SEL_CS1;
                if (shared) ofs = ofs & ~top;
                ofs_out = half ? (ofs >> 1) : ofs;
            end
        end
    end
endmodule

// File: rtl/ebus_win_decode.sv
module ebus_win_decode
    import ebw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int WOFS = 28,
    parameter logic [AW-WOFS-1:0] RGN1 = (AW-WOFS)'(6),
    parameter logic [AW-WOFS-1:0] RGN2 = (AW-WOFS)'(8),
    parameter logic [AW-WOFS-1:0] RGN3 = (AW-WOFS)'(10)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    input  logic            dual_mode,
    input  logic            half_mode,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    output logic            dec_done,
    output logic            dec_fault,
    output logic            cs0_n,
    output logic            cs1_n,
    output logic [WOFS-1:0] dec_offset
);
    localparam int NWIN = 2;

    ebw_cfg_t        cfg;
    logic            ebw_unused_wdata;
    logic [1:0]      w_base [NWIN];
    logic [1:0]      w_size [NWIN];
    logic            w_hit  [NWIN];
    logic            w_over [NWIN];
    logic [WOFS-1:0] w_top  [NWIN];
    logic [WOFS-1:0] w_ofs  [NWIN];
    ebw_sel_e        nx_sel;
    logic            nx_fault;
    logic [WOFS-1:0] nx_ofs;

    assign ebw_unused_wdata = ^cfg_wdata[DW-1:CFG_BITS];

    ebw_cfg_reg #(.DW(DW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata[CFG_BITS-1:0]),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    // Window 0 is the peripheral window, window 1 the memory window.
    assign w_base[0] = cfg.per_base;
    assign w_size[0] = cfg.per_size;
    assign w_base[1] = cfg.mem_base;
    assign w_size[1] = cfg.mem_size;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        ebw_window #(
            .AW(AW), .WOFS(WOFS), .RGN1(RGN1), .RGN2(RGN2), .RGN3(RGN3)
        ) u_win (
            .addr      (req_addr),
            .base_sel  (w_base[i]),
            .size_code (w_size[i]),
            .half      (half_mode),
            .hit       (w_hit[i]),
            .over      (w_over[i]),
            .top_bit   (w_top[i]),
            .ofs       (w_ofs[i])
        );
    end

    ebw_steer #(.WOFS(WOFS)) u_steer (
        .dual    (dual_mode),
        .half    (half_mode),
        .per_en  (cfg.per_base != 2'd0),
        .mem_en  (cfg.mem_base != 2'd0),
        .p_hit   (w_hit[0]),
        .p_over  (w_over[0]),
        .p_top   (w_top[0]),
        .p_ofs   (w_ofs[0]),
        .m_hit   (w_hit[1]),
        .m_over  (w_over[1]),
        .m_top   (w_top[1]),
        .m_ofs   (w_ofs[1]),
        .sel     (nx_sel),
        .fault   (nx_fault),
        .ofs_out (nx_ofs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_done   <= 1'b0;
            dec_fault  <= 1'b0;
            cs0_n      <= 1'b1;
            cs1_n      <= 1'b1;
            dec_offset <= '0;
        end else begin
            dec_done   <= req_valid;
            dec_fault  <= req_valid && nx_fault;
            cs0_n      <= !(req_valid && nx_sel == SEL_CS0);
            cs1_n      <= !(req_valid && nx_sel == SEL_CS1);
            dec_offset <= req_valid ? nx_ofs : '0;
        end
    end
endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
    parameter int DW   = 32,
    parameter int WOFS = 28
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic [DW-1:0]   cfg_wdata,
    input logic [DW-1:0]   cfg_rdata,
    input logic            dual_mode,
    input logic            half_mode,
    input logic            req_valid,
    input logic            dec_done,
    input logic            dec_fault,
    input logic            cs0_n,
    input logic            cs1_n,
    input logic [WOFS-1:0] dec_offset
);
    p_cfg_write_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[7:0] == $past(cfg_wdata[7:0]));

    p_done_after_req_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_done);

    p_no_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !dec_done);

    p_idle_cs_high_r10: assert property (@(posedge clk) disable iff (rst)
        !dec_done |-> (cs0_n && cs1_n));

    p_cs_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(!cs0_n && !cs1_n));

    p_fault_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        dec_fault |-> (cs0_n && cs1_n && dec_done && dec_offset == '0));

    p_single_cs0_only_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !dual_mode) |=> cs1_n);

    p_half_top_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && half_mode) |=> !dec_offset[WOFS-1]);
endmodule

bind ebus_win_decode ebw_checker #(.DW(DW), .WOFS(WOFS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .dual_mode  (dual_mode),
    .half_mode  (half_mode),
    .req_valid  (req_valid),
    .dec_done   (dec_done),
    .dec_fault  (dec_fault),
    .cs0_n      (cs0_n),
    .cs1_n      (cs1_n),
    .dec_offset (dec_offset)
);

// File: tb/sim_ebus_win_decode.sv
`timescale 1ns/1ps
module sim_ebus_win_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dual_mode = 1'b0;
    logic        half_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        dec_done, dec_fault, cs0_n, cs1_n;
    logic [27:0] dec_offset;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ebus_win_decode u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dual_mode(dual_mode), .half_mode(half_mode),
        .req_valid(req_valid), .req_addr(req_addr), .dec_done(dec_done),
        .dec_fault(dec_fault), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .dec_offset(dec_offset)
    );

    function automatic logic [3:0] rgn_of(input logic [1:0] b);
        case (b)
            2'd1:    return 4'h6;
            2'd2:    return 4'h8;
            default: return 4'hA;
        endcase
    endfunction

    function automatic longint span_of(input logic [1:0] code, input logic half);
        longint s;
        s = (code == 2'd3) ? (64'd1 << 28) : (64'd256 << (8 * code));
        if (half) s = s * 2;
        if (s > (64'd1 << 28)) s = 64'd1 << 28;
        return s;
    endfunction

    // Expected {done, fault, cs0_n, cs1_n, offset}, computed from the requirements.
    function automatic logic [31:0] model(input logic [7:0] c, input logic dual,
                                          input logic half, input logic [31:0] a,
                                          output string tag);
        logic [1:0] pb, ps, mb, ms, code;
        logic ph, mh, win_p, found, shared, cs1;
        longint off, s;
        pb = c[5:4]; ps = c[7:6]; mb = c[1:0]; ms = c[3:2];
        ph = (pb != 0) && (a[31:28] == rgn_of(pb));
        mh = (mb != 0) && (a[31:28] == rgn_of(mb));
        found = 1'b0; win_p = 1'b0; shared = 1'b0; cs1 = 1'b0;
        tag = "R6";
        if (!dual) begin
            found = ph || mh; win_p = ph;
        end else if (pb != 0 && mb != 0) begin
            found = ph || mh; win_p = ph; cs1 = !ph; tag = "R8";
        end else if (pb != 0) begin
            found = ph; win_p = 1'b1; shared = 1'b1; tag = "R7";
        end else if (mb != 0) begin
            found = mh; shared = 1'b1; tag = "R7";
        end
        if (!found) begin
            tag = "R4";
            return {1'b1, 1'b0, 1'b1, 1'b1, 28'd0};
        end
        code = win_p ? ps : ms;
        s = span_of(code, half);
        off = longint'(a[27:0]);
        if (off >= s) begin
            tag = "R5";
            return {1'b1, 1'b1, 1'b1, 1'b1, 28'd0};
        end
        if (shared) begin
            cs1 = (off >= s / 2);
            if (cs1) off = off - s / 2;
        end
        if (half) begin
            off = off / 2;
            tag = {tag, "/R9"};
        end else begin
            tag = {tag, "/R3"};
        end
        return {1'b1, 1'b0, cs1, !cs1, off[27:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {dec_done, dec_fault, cs0_n, cs1_n, dec_offset};
    endfunction

    task automatic write_cfg(input logic [7:0] c);
        cfg_we    = 1'b1;
        cfg_wdata = {24'hA5C3F1, c};
        req_valid = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        // R1: stored fields read back, upper bits read zero
        check("R1", cfg_rdata, {24'd0, c});
        // R10: no request in the previous cycle, so no done and both selects high
        check("R10", {28'd0, dec_done, dec_fault, cs0_n, cs1_n}, 32'h3);
    endtask

    task automatic run_req(input logic [7:0] c, input logic d, input logic h,
                           input logic [31:0] a);
        logic [31:0] exp;
        string tag;
        dual_mode = d;
        half_mode = h;
        req_addr  = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        exp = model(c, d, h, a, tag);
        // R2, R10, R11 are covered by every comparison here
        check(tag, outs(), exp);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    logic [3:0]  rgns [4] = '{4'h6, 4'h8, 4'hA, 4'h3};
    logic [27:0] offs [14] = '{28'h0, 28'hFF, 28'h100, 28'h7F, 28'h80, 28'h1FF,
                               28'h8000, 28'hFFFF, 28'h10000, 28'h800000,
                               28'hFFFFFF, 28'h1000000, 28'h8000000, 28'hFFFFFFF};

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R10: reset state
        check("R1", cfg_rdata, 32'd0);
        check("R10", {28'd0, dec_done, dec_fault, cs0_n, cs1_n}, 32'h3);
        for (int c = 0; c < 256; c++) begin
            write_cfg(8'(c));
            for (int m = 0; m < 4; m++) begin
                for (int r = 0; r < 4; r++) begin
                    for (int k = 0; k < 14; k++) begin
                        run_req(8'(c), m[0], m[1], {rgns[r], offs[k]});
                    end
                end
            end
        end
        // R10: an idle cycle after the sweep shows no done
        @(negedge clk);
        check("R10", {28'd0, dec_done, dec_fault, cs0_n, cs1_n}, 32'h3);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule